// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block sits on the host side of an external 12-bit analog-to-digital converter that has a parallel data bus. It runs the converter's handshake and nothing else. It sends an active-low convert-start pulse and waits for the converter's active-low end-of-conversion strobe. It then asserts an active-low chip-select and an active-low read strobe, and captures the returned word into a holding register together with a one-cycle valid pulse. Every timing rule comes from the system clock. Each rule is a parameter given in nanoseconds, and the block turns it into a cycle count by rounding up. These rules cover the convert-start width, the read width and data access time, the recovery gap after read, and the acquisition interval.

A single-cycle pulse on the start input runs one conversion. While the continuous input is held high, conversions follow each other as fast as the timing rules allow. The wait for end-of-conversion is bounded. If the strobe does not arrive within the longest conversion time plus a margin, a sticky error flag is raised and the controller goes back to idle with every strobe released. A parameter selects the longer recovery gap that is needed when the data lines drive TTL loads.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held and just after it is released, conv_n_o, cs_n_o and rd_n_o are high, busy_o, valid_o and err_o are low, and data_o is zero.
- R2: From idle, start_i or cont_i drives conv_n_o low for exactly ceil(CONV_PULSE_NS/CLK_PERIOD_NS) cycles, 5 with the default parameters. busy_o is high whenever conv_n_o or cs_n_o is low.
- R3: cs_n_o and rd_n_o stay high from convert-start until a falling edge of eoc_n_i has been seen. The input passes through SYNC_STAGES flops, 2 by default, so cs_n_o falls no more than 4 cycles after eoc_n_i goes low.
- R4: rd_n_o falls one cycle after cs_n_o. It stays low for max(ceil(RD_PULSE_NS/T), ceil(DATA_ACCESS_NS/T)+1) cycles, 5 with the defaults. cs_n_o is low on every cycle that rd_n_o is low, and both rise on the same edge.
- R5: data_o takes the value of adc_data_i from the last cycle that rd_n_o is low. valid_o is high for exactly the one cycle that follows that edge.
- R6: The next convert-start, or the fall of busy_o, comes no sooner than the recovery count after rd_n_o rises. The recovery count is ceil(200 ns/T), which is 20, when TTL_LOAD is 0, and ceil(400 ns/T) when TTL_LOAD is 1.
- R7: The next convert-start, or the fall of busy_o, comes no sooner than ceil(ACQ_NS/T) cycles after cs_n_o falls, which is 40 with the defaults.
- R8: While cont_i is high at the end of recovery, a new convert-start begins with no idle cycle between. If cont_i is low at that point, busy_o falls and the block goes idle.
- R9: A start_i pulse that arrives while busy_o is high has no effect. No additional conversion follows it.
- R10: If no eoc_n_i fall arrives within ceil(CONV_MAX_NS/T)+TMO_MARGIN_CYC cycles after conv_n_o rises, err_o is set and the block goes idle with busy_o low and all strobes high. This never happens sooner than ceil(CONV_MAX_NS/T) cycles, which is 168 with the defaults.
- R11: err_o stays high until reset, and conversions started after it complete normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Runs one conversion when idle |
| cont_i | input | 1 | Repeats conversions while high |
| eoc_n_i | input | 1 | Active-low end-of-conversion strobe from the converter |
| adc_data_i | input | DATA_W | Converter data bus |
| conv_n_o | output | 1 | Active-low convert-start pulse |
| cs_n_o | output | 1 | Active-low chip-select |
| rd_n_o | output | 1 | Active-low read strobe |
| busy_o | output | 1 | High from convert-start until recovery ends |
| data_o | output | DATA_W | Last captured conversion word |
| valid_o | output | 1 | One-cycle pulse with each new word |
| err_o | output | 1 | Sticky end-of-conversion timeout flag |

## Verification
A wrong phase counter shows up on the strobe that phase drives, in the same conversion. The wrong value appears as a convert-start or read width that is off by a cycle, or as a word latched before the modelled converter has put valid data on the bus. A wrong recovery or acquisition counter shows as a convert-start that comes too early in continuous mode, or as busy_o falling too early after a single conversion, both seen within about forty cycles of the read. A state machine that leaves WAIT early or late shows as a chip-select before the end-of-conversion edge, or as the timeout flag rising outside its window of roughly 176 cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT,
        ST_SEL,
        ST_READ,
        ST_RECOV
    } seq_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_seq_eoc_edge.sv
module adc_seq_eoc_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic eoc_n_i,
    output logic fall_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_regs_t;

    edge_regs_t regs_d, regs_q;

    always_comb begin
        regs_d      = regs_q;
        regs_d.sync = {regs_q.sync[SYNC_STAGES-2:0], eoc_n_i};
        regs_d.prev = regs_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign fall_o = regs_q.prev & ~regs_q.sync[SYNC_STAGES-1];

    // R3
    fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);

endmodule

// File: rtl/adc_seq_interval.sv
module adc_seq_interval #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);

    // R7
    hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !load_i) |=> done_o);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CLK_PERIOD_NS  = 10,
    parameter int DATA_W         = 12,
    parameter int CONV_PULSE_NS  = 45,
    parameter int CONV_MAX_NS    = 1680,
    parameter int TMO_MARGIN_CYC = 8,
    parameter int RD_PULSE_NS    = 45,
    parameter int DATA_ACCESS_NS = 40,
    parameter int RECOV_CMOS_NS  = 200,
    parameter int RECOV_TTL_NS   = 400,
    parameter int ACQ_NS         = 400,
    parameter bit TTL_LOAD       = 1'b0,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              cont_i,
    input  logic              eoc_n_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              conv_n_o,
    output logic              cs_n_o,
    output logic              rd_n_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int CNV_CYC   = max2(ceil_div(CONV_PULSE_NS, CLK_PERIOD_NS), 1);
    localparam int RD_CYC    = max2(ceil_div(RD_PULSE_NS, CLK_PERIOD_NS),
                                    ceil_div(DATA_ACCESS_NS, CLK_PERIOD_NS) + 1);
    localparam int RECOV_NS  = TTL_LOAD ? RECOV_TTL_NS : RECOV_CMOS_NS;
    localparam int RECOV_CYC = max2(ceil_div(RECOV_NS, CLK_PERIOD_NS), 1);
    localparam int TMO_CYC   = ceil_div(CONV_MAX_NS, CLK_PERIOD_NS) + TMO_MARGIN_CYC;
    localparam int ACQ_CYC   = max2(ceil_div(ACQ_NS, CLK_PERIOD_NS), 1);
    localparam int MAX_CYC   = max2(max2(CNV_CYC, RD_CYC),
                                    max2(max2(RECOV_CYC, TMO_CYC), ACQ_CYC));
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              conv_n;
        logic              cs_n;
        logic              rd_n;
        logic              busy;
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] data;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st:     ST_IDLE,
        cnt:    '0,
        conv_n: 1'b1,
        cs_n:   1'b1,
        rd_n:   1'b1,
        busy:   1'b0,
        valid:  1'b0,
        err:    1'b0,
        data:   '0
    };

    regs_t regs_d, regs_q;
    logic  eoc_fall;
    logic  acq_load;
    logic  acq_done;

    adc_seq_eoc_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) eoc_edge_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .eoc_n_i(eoc_n_i),
        .fall_o (eoc_fall)
    );

    adc_seq_interval #(
        .CNT_W(CNT_W)
    ) acq_timer_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (acq_load),
        .load_val_i(CNT_W'(ACQ_CYC - 1)),
        .done_o    (acq_done)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.valid = 1'b0;
        acq_load     = 1'b0;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (start_i || cont_i) begin
                    regs_d.st     = ST_CONV;
                    regs_d.conv_n = 1'b0;
                    regs_d.busy   = 1'b1;
                    regs_d.cnt    = CNT_W'(CNV_CYC - 1);
                end
            end
            ST_CONV: begin
                if (regs_q.cnt == '0) begin
                    regs_d.st     = ST_WAIT;
                    regs_d.conv_n = 1'b1;
                    regs_d.cnt    = CNT_W'(TMO_CYC - 1);
                end else begin
                    regs_d.cnt = regs_q.cnt - 1'b1;
                end
            end
            ST_WAIT: begin
                if (eoc_fall) begin
                    regs_d.st   = ST_SEL;
                    regs_d.cs_n = 1'b0;
                    acq_load    = 1'b1;
                end else if (regs_q.cnt == '0) begin
                    regs_d.st   = ST_IDLE;
                    regs_d.busy = 1'b0;
                    regs_d.err  = 1'b1;
                end else begin
                    regs_d.cnt = regs_q.cnt - 1'b1;
                end
            end
            ST_SEL: begin
                regs_d.st   = ST_READ;
                regs_d.rd_n = 1'b0;
                regs_d.cnt  = CNT_W'(RD_CYC - 1);
            end
            ST_READ: begin
                if (regs_q.cnt == '0) begin
                    regs_d.st    = ST_RECOV;
                    regs_d.rd_n  = 1'b1;
                    regs_d.cs_n  = 1'b1;
                    regs_d.data  = adc_data_i;
                    regs_d.valid = 1'b1;
                    regs_d.cnt   = CNT_W'(RECOV_CYC - 1);
                end else begin
                    regs_d.cnt = regs_q.cnt - 1'b1;
                end
            end
            ST_RECOV: begin
                if (regs_q.cnt != '0) begin
                    regs_d.cnt = regs_q.cnt - 1'b1;
                end else if (acq_done) begin
                    if (cont_i) begin
                        regs_d.st     = ST_CONV;
                        regs_d.conv_n = 1'b0;
                        regs_d.cnt    = CNT_W'(CNV_CYC - 1);
                    end else begin
                        regs_d.st   = ST_IDLE;
                        regs_d.busy = 1'b0;
                    end
                end
            end
            default: regs_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q <= REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign conv_n_o = regs_q.conv_n;
    assign cs_n_o   = regs_q.cs_n;
    assign rd_n_o   = regs_q.rd_n;
    assign busy_o   = regs_q.busy;
    assign data_o   = regs_q.data;
    assign valid_o  = regs_q.valid;
    assign err_o    = regs_q.err;

    // R4
    rd_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_n_o |-> !cs_n_o);

    // R5
    valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R3
    conv_read_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !conv_n_o |-> (cs_n_o && rd_n_o));

    // R2
    busy_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!conv_n_o || !cs_n_o) |-> busy_o);

    // R10
    timeout_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> (!busy_o && conv_n_o && cs_n_o && rd_n_o));

    // R11
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o);

endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int EXP_CNV    = (45 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_RD     = 5;
    localparam int EXP_RECOV  = (200 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_ACQ    = (400 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_TMO    = (1680 + CLK_PERIOD - 1) / CLK_PERIOD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cont = 1'b0;
    logic        eoc_n = 1'b1;
    logic [11:0] adc_data = 12'h000;
    logic        conv_n, cs_n, rd_n, busy, valid, err;
    logic [11:0] data;

    int tests_run = 0;
    int tests_failed = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .start_i   (start),
        .cont_i    (cont),
        .eoc_n_i   (eoc_n),
        .adc_data_i(adc_data),
        .conv_n_o  (conv_n),
        .cs_n_o    (cs_n),
        .rd_n_o    (rd_n),
        .busy_o    (busy),
        .data_o    (data),
        .valid_o   (valid),
        .err_o     (err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Acts as the converter for one conversion and checks the handshake.
    task automatic serve_conv(input logic [11:0] word, input int delay,
                              input int poke_at, input bit expect_next);
        int t = 0;
        int n = 0;
        int rd_len = 0;
        int e = 0;
        int e_cs = -1;
        int gap = 0;
        bit early = 0;
        bit cs_bad = 0;
        bit seen_valid = 0;
        logic [11:0] got = 12'h000;
        while (conv_n && t < 300) begin @(negedge clk); t++; end
        check(conv_n == 1'b0, "R2", "convert-start seen", conv_n, 0);
        while (!conv_n && n < 50) begin @(negedge clk); n++; end
        check(n == EXP_CNV, "R2", "convert-start width", n, EXP_CNV);
        for (int i = 0; i < delay; i++) begin
            if (!cs_n || !rd_n) early = 1;
            start = (i == poke_at);
            @(negedge clk);
        end
        start = 1'b0;
        check(!early, "R3", "strobes idle before end-of-conversion", early, 0);
        eoc_n = 1'b0;
        adc_data = ~word;
        t = 0;
        while (t < 80 && !seen_valid) begin
            if (t == 7) eoc_n = 1'b1;
            if (!cs_n && e_cs < 0) e_cs = e;
            if (!rd_n) begin
                rd_len++;
                if (cs_n) cs_bad = 1;
            end
            adc_data = (!rd_n && rd_len >= EXP_RD) ? word : ~word;
            if (valid) begin seen_valid = 1; got = data; end
            if (!seen_valid) begin @(negedge clk); t++; e++; end
        end
        eoc_n = 1'b1;
        check(e_cs >= 1 && e_cs <= 4, "R3", "chip-select delay after eoc", e_cs, 3);
        check(rd_len == EXP_RD, "R4", "read width", rd_len, EXP_RD);
        check(!cs_bad && cs_n && rd_n, "R4", "cs low around read", cs_bad, 0);
        check(seen_valid && got == word, "R5", "captured word", got, word);
        @(negedge clk); gap = 1; e++;
        check(valid == 1'b0, "R5", "valid single cycle", valid, 0);
        while (conv_n && busy && gap < 200) begin @(negedge clk); gap++; e++; end
        check(gap >= EXP_RECOV, "R6", "read release to next start", gap, EXP_RECOV);
        check(e - e_cs >= EXP_ACQ, "R7", "cs fall to next start", e - e_cs, EXP_ACQ);
        if (expect_next)
            check(conv_n == 1'b0 && busy, "R8", "back-to-back start", conv_n, 0);
        else
            check(!busy && conv_n, "R8", "idle after last conversion", busy, 0);
    endtask

    task automatic test_reset;
        check(conv_n && cs_n && rd_n, "R1", "strobes high in reset", {conv_n, cs_n, rd_n}, 7);
        check(!busy && !valid && !err, "R1", "flags low in reset", {busy, valid, err}, 0);
        check(data == 12'h000, "R1", "data zero in reset", data, 0);
    endtask

    task automatic test_single;
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        serve_conv(12'hA5C, 140, -1, 1'b0);
    endtask

    task automatic test_start_ignored;
        bit extra = 0;
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        serve_conv(12'h5A3, 100, 30, 1'b0);
        for (int i = 0; i < 80; i++) begin
            if (!conv_n || busy) extra = 1;
            @(negedge clk);
        end
        check(!extra, "R9", "start during busy ignored", extra, 0);
    endtask

    task automatic test_continuous;
        @(negedge clk); cont = 1'b1;
        serve_conv(12'hFFF, 150, -1, 1'b1);
        serve_conv(12'h000, 130, -1, 1'b1);
        cont = 1'b0;
        serve_conv(12'h81E, 145, -1, 1'b0);
    endtask

    task automatic test_timeout;
        int t = 0;
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        while (conv_n && t < 50) begin @(negedge clk); t++; end
        while (!conv_n && t < 100) begin @(negedge clk); t++; end
        t = 0;
        while (!err && t < 400) begin
            if (!cs_n) t = 1000;
            @(negedge clk); t++;
        end
        check(err && t >= EXP_TMO && t <= EXP_TMO + 20, "R10", "timeout cycle", t, EXP_TMO + 8);
        check(!busy && conv_n && cs_n && rd_n, "R10", "idle after timeout", busy, 0);
    endtask

    task automatic test_sticky;
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        serve_conv(12'h3F0, 120, -1, 1'b0);
        check(err == 1'b1, "R11", "error flag sticky", err, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_single();
        test_start_ignored();
        test_continuous();
        test_timeout();
        test_sticky();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule